// File: doc/BRIEF.md
# Configurable Bit-Serial Key Schedule

This block feeds a bit-serial round datapath with one round-key bit per clock. It holds two, three or four key words of a selectable width (16, 24, 32, 48 or 64 bits). While it steps, it emits the current round key least significant bit first. At the same time it computes the key word for a later round, one bit per cycle, and writes it into the top word store. All word stores move down by one word per round, so after n steps the next round key is at the bottom.

The key is shifted in serially before use. The one-bit round constant for each round comes from an external sequence source. The block reads it in the first cycle of every round. Rotations are handled by direct taps into the top word store and by short capture registers that hold the low bits of a word before they shift out. This lets every rotation be read in plain bit order without a second copy of any word.

Top module: `keysched_serial`

## Requirements
- R1: After reset the bit counter is 0, all word stores are cleared, keyBit is 0 and lastBit is 0.
- R2: With loadEn high, loadBit is shifted in one bit per clock: word 0 LSB first, then word 1 and so on up to word m-1, for m*n cycles in total. The first m rounds of stepping then output exactly those words in that order, LSB first.
- R3: With modeSel 0 (two words), the word produced in a round is K_i ^ rotr3(K_i+1) ^ rotr4(K_i+1) ^ C, where all rotations are within n bits.
- R4: With modeSel 1 (three words), the produced word is K_i ^ rotr3(K_i+2) ^ rotr4(K_i+2) ^ C.
- R5: With modeSel 2 or 3 (four words), the produced word is K_i ^ rotr3(K_i+3) ^ rotr4(K_i+3) ^ K_i+1 ^ rotr1(K_i+1) ^ C.
- R6: C has every bit set except bit 1, which is 0, and bit 0, which equals rcBit as sampled in the round's first stepping cycle. rcBit is ignored in every other cycle.
- R7: wordSel selects the word width n: 0 gives 16, 1 gives 24, 2 gives 32, 3 gives 48, and any other code gives 64.
- R8: In a cycle with loadEn and stepEn both low, no state changes, so keyBit holds its value.
- R9: lastBit is high exactly in the stepping cycle that presents bit n-1 of a round key, and the following step presents bit 0 of the next key.
- R10: loadEn takes priority over stepEn. A load started in the middle of a round restarts the bit counter, so that stepping after the load begins at bit 0 of the newly loaded word 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wordSel | input | 3 | Word width code (R7) |
| modeSel | input | 2 | Key word count code (R3 to R5) |
| loadEn | input | 1 | Serial key load strobe |
| loadBit | input | 1 | Serial key data bit |
| stepEn | input | 1 | Advance one round-key bit |
| rcBit | input | 1 | Round constant bit for the current round |
| keyBit | output | 1 | Current round-key bit, LSB first |
| lastBit | output | 1 | Marks bit n-1 of a round key |

## Verification
On every cycle the assertions check the bit counter's sequencing: it advances by one on each step, it returns to zero after the last bit of a round and after any load, and it and the output bit both hold during idle cycles. The values of the expanded key words cannot be seen by any single-cycle property. Only the scenarios show them, by comparing every emitted bit against a word-level model in all three key-word modes and several widths. The scenarios also cover an all-zero key that exposes the constant word, idle gaps inside rounds, and a load that interrupts a round.

// File: rtl/keysched_pkg.sv
package keysched_pkg;

  typedef enum logic [1:0] {
    KW2 = 2'd0,
    KW3 = 2'd1,
    KW4 = 2'd2
  } kwMode_e;

  // Strobes from the sequencer to the word stores
  typedef struct packed {
    logic       shift;     // move every store by one bit
    logic       load;      // top store takes the serial key bit
    logic       capTop;    // capture a low bit of the top word
    logic [1:0] capIdx;    // slot for that capture
    logic       capK1;     // capture bit 0 of the second word
    logic       useTail3;  // rotr3 tap has wrapped
    logic       useTail4;  // rotr4 tap has wrapped
    logic       useTail1;  // rotr1 tap has wrapped
    logic [1:0] idx3;      // capture slot for rotr3 once wrapped
    logic [1:0] idx4;      // capture slot for rotr4 once wrapped
    logic       cBit;      // constant word bit for this position
  } ksStrobe_t;

  function automatic kwMode_e decodeMode(input logic [1:0] code);
    case (code)
      2'd0:    return KW2;
      2'd1:    return KW3;
      default: return KW4;
    endcase
  endfunction

  function automatic int unsigned wordLen(input logic [2:0] code);
    case (code)
      3'd0:    return 16;
      3'd1:    return 24;
      3'd2:    return 32;
      3'd3:    return 48;
      default: return 64;
    endcase
  endfunction

endpackage

// File: rtl/keysched_ctrl.sv
module keysched_ctrl
  import keysched_pkg::*;
#(
  parameter int MAXN = 64,
  localparam int IW = $clog2(MAXN)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [2:0]    wordSel,
  input  logic          loadEn,
  input  logic          stepEn,
  input  logic          rcBit,
  output ksStrobe_t     stb,
  output logic [IW-1:0] lenM1,
  output logic [IW-1:0] bitIdx,
  output logic          lastBit
);

  logic [IW:0] idxW;
  logic [IW:0] lenW;
  logic        stepOnly;

  assign lenM1    = IW'(wordLen(wordSel) - 1);
  assign idxW     = {1'b0, bitIdx};
  assign lenW     = {1'b0, lenM1};
  assign stepOnly = stepEn && !loadEn;
  assign lastBit  = stepOnly && (bitIdx == lenM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitIdx <= '0;
    end else if (loadEn) begin
      bitIdx <= '0;
    end else if (stepEn) begin
      bitIdx <= (bitIdx == lenM1) ? '0 : bitIdx + 1'b1;
    end
  end

  // Widths are multiples of 4, so wrapped capture slots are the low two bits
  always_comb begin
    stb          = '0;
    stb.shift    = loadEn || stepEn;
    stb.load     = loadEn;
    stb.capTop   = stepOnly && (bitIdx < IW'(4));
    stb.capIdx   = bitIdx[1:0];
    stb.capK1    = stepOnly && (bitIdx == '0);
    stb.useTail3 = (idxW + (IW+1)'(3)) > lenW;
    stb.useTail4 = (idxW + (IW+1)'(4)) > lenW;
    stb.useTail1 = (bitIdx == lenM1);
    stb.idx3     = bitIdx[1:0] + 2'd3;
    stb.idx4     = bitIdx[1:0];
    if (bitIdx == '0)          stb.cBit = rcBit;
    else if (bitIdx == IW'(1)) stb.cBit = 1'b0;
    else                       stb.cBit = 1'b1;
  end

endmodule

// File: rtl/keysched_dp.sv
module keysched_dp
  import keysched_pkg::*;
#(
  parameter int MAXN = 64,
  localparam int IW = $clog2(MAXN),
  localparam int NSTORE = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  ksStrobe_t     stb,
  input  kwMode_e       mode,
  input  logic [IW-1:0] lenM1,
  input  logic          loadBit,
  output logic          keyBit
);

  logic [NSTORE-1:0][MAXN-1:0] st;
  logic [NSTORE-1:0]           inBit;
  logic [3:0]                  tailTop;
  logic                        tailK1;
  logic                        rot3, rot4, rot1K1, mixK1, newBit;

  // Stores 0 and 3 always used; 2 joins for three words; 1 for four
  always_comb begin
    inBit[3] = stb.load ? loadBit : newBit;
    inBit[2] = st[3][0];
    inBit[1] = st[2][0];
    case (mode)
      KW2:     inBit[0] = st[3][0];
      KW3:     inBit[0] = st[2][0];
      default: inBit[0] = st[1][0];
    endcase
  end

  for (genvar g = 0; g < NSTORE; g++) begin : gStore
    logic [MAXN-1:0] nx;
    logic [MAXN-1:0] q;
    always_comb begin
      nx        = {1'b0, q[MAXN-1:1]};
      nx[lenM1] = inBit[g];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          q <= '0;
      else if (stb.shift) q <= nx;
    end
    assign st[g] = q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tailTop <= '0;
      tailK1  <= 1'b0;
    end else begin
      if (stb.capTop) tailTop[stb.capIdx] <= st[3][0];
      if (stb.capK1)  tailK1 <= st[1][0];
    end
  end

  always_comb begin
    rot3   = stb.useTail3 ? tailTop[stb.idx3] : st[3][3];
    rot4   = stb.useTail4 ? tailTop[stb.idx4] : st[3][4];
    rot1K1 = stb.useTail1 ? tailK1 : st[1][1];
    mixK1  = (mode == KW4) ? (st[1][0] ^ rot1K1) : 1'b0;
    newBit = st[0][0] ^ rot3 ^ rot4 ^ mixK1 ^ stb.cBit;
  end

  assign keyBit = st[0][0];

endmodule

// File: rtl/keysched_serial.sv
module keysched_serial
  import keysched_pkg::*;
#(
  parameter int MAXN = 64,
  localparam int IW = $clog2(MAXN)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] wordSel,
  input  logic [1:0] modeSel,
  input  logic       loadEn,
  input  logic       loadBit,
  input  logic       stepEn,
  input  logic       rcBit,
  output logic       keyBit,
  output logic       lastBit
);

  ksStrobe_t     stb;
  logic [IW-1:0] lenM1;
  logic [IW-1:0] bitIdx;
  kwMode_e       mode;

  assign mode = decodeMode(modeSel);

  keysched_ctrl #(.MAXN(MAXN)) u_ctl (
    .clk(clk), .rstN(rstN), .wordSel(wordSel), .loadEn(loadEn),
    .stepEn(stepEn), .rcBit(rcBit), .stb(stb), .lenM1(lenM1),
    .bitIdx(bitIdx), .lastBit(lastBit)
  );

  keysched_dp #(.MAXN(MAXN)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .mode(mode), .lenM1(lenM1),
    .loadBit(loadBit), .keyBit(keyBit)
  );

endmodule

// File: rtl/keysched_chk.sv
module keysched_chk #(
  parameter int IW = 6
) (
  input logic          clk,
  input logic          rstN,
  input logic          loadEn,
  input logic          stepEn,
  input logic          keyBit,
  input logic          lastBit,
  input logic [IW-1:0] bitIdx
);

  a_r8_idle_hold_key: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && !stepEn) |=> $stable(keyBit));

  a_r8_idle_hold_idx: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn && !stepEn) |=> $stable(bitIdx));

  a_r9_wrap_after_last: assert property (@(posedge clk) disable iff (!rstN)
    lastBit |=> (bitIdx == '0));

  a_r9_step_advance: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && !loadEn && !lastBit) |=> (bitIdx == $past(bitIdx) + 1'b1));

  a_r10_load_restart: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> (bitIdx == '0));

endmodule

bind keysched_serial keysched_chk #(.IW(IW)) u_chk (
  .clk(clk), .rstN(rstN), .loadEn(loadEn), .stepEn(stepEn),
  .keyBit(keyBit), .lastBit(lastBit), .bitIdx(bitIdx)
);

// File: tb/keysched_serial_tb.sv
module keysched_serial_tb;

  typedef struct {
    logic  b;
    logic  last;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] wordSel;
  logic [1:0] modeSel;
  logic       loadEn, loadBit, stepEn, rcBit;
  logic       keyBit, lastBit;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  longint unsigned w[4];
  int    mCur, nCur, roundCnt;
  string tagOverride;
  exp_t  q[$];

  always #5 clk = ~clk;

  keysched_serial u_dut (
    .clk(clk), .rstN(rstN), .wordSel(wordSel), .modeSel(modeSel),
    .loadEn(loadEn), .loadBit(loadBit), .stepEn(stepEn), .rcBit(rcBit),
    .keyBit(keyBit), .lastBit(lastBit)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic longint unsigned maskN(input int n);
    return (n == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << n) - 64'd1);
  endfunction

  function automatic longint unsigned rotr(input longint unsigned x, input int r, input int n);
    return ((x >> r) | (x << (n - r))) & maskN(n);
  endfunction

  function automatic int widthOf(input logic [2:0] code);
    case (code)
      3'd0: return 16;
      3'd1: return 24;
      3'd2: return 32;
      3'd3: return 48;
      default: return 64;
    endcase
  endfunction

  // Word-level model of one expansion and shift
  task automatic modelAdvance(input logic rc);
    longint unsigned nw, top;
    top = w[mCur-1];
    nw = w[0] ^ rotr(top, 3, nCur) ^ rotr(top, 4, nCur);
    if (mCur == 4) nw ^= w[1] ^ rotr(w[1], 1, nCur);
    nw ^= maskN(nCur) & ~64'd3;
    nw ^= {63'd0, rc};
    for (int k = 0; k < 3; k++) w[k] = w[k+1];
    w[mCur-1] = nw;
    roundCnt++;
  endtask

  task automatic loadKey(input logic [2:0] sel, input logic [1:0] mcode,
                         input longint unsigned k0, input longint unsigned k1,
                         input longint unsigned k2, input longint unsigned k3,
                         input bit alsoStep);
    longint unsigned kk[4];
    kk[0] = k0; kk[1] = k1; kk[2] = k2; kk[3] = k3;
    wordSel = sel;
    modeSel = mcode;
    nCur = widthOf(sel);
    mCur = (mcode == 2'd0) ? 2 : (mcode == 2'd1) ? 3 : 4;
    loadEn = 1'b1;
    stepEn = alsoStep;
    for (int wi = 0; wi < mCur; wi++) begin
      kk[wi] &= maskN(nCur);
      for (int b = 0; b < nCur; b++) begin
        loadBit = kk[wi][b];
        rcBit = 1'($urandom_range(0, 1));
        @(negedge clk);
      end
    end
    loadEn = 1'b0;
    stepEn = 1'b0;
    for (int k = 0; k < 4; k++) w[k] = kk[k];
    roundCnt = 0;
  endtask

  function automatic string reqFor();
    if (tagOverride != "") return tagOverride;
    if (roundCnt < mCur) return "R2";
    if (mCur == 2) return "R3";
    if (mCur == 3) return "R4";
    return "R5";
  endfunction

  // Driver: pushes expected bits, gapAt inserts an idle stretch mid-round
  task automatic stepRound(input int nBits, input int gapAt);
    logic rc;
    exp_t e;
    rc = 1'($urandom_range(0, 1));
    for (int j = 0; j < nBits; j++) begin
      if (j == gapAt) begin
        logic held;
        stepEn = 1'b0;
        rcBit = ~rc;
        #3;
        held = keyBit;
        repeat (3) @(negedge clk);
        #3;
        check(keyBit === held, "R8", "keyBit over idle", keyBit, held);
        @(negedge clk);
      end
      stepEn = 1'b1;
      rcBit = (j == 0) ? rc : 1'($urandom_range(0, 1));
      e.b = w[0][j];
      e.last = (j == nCur - 1);
      e.req = reqFor();
      q.push_back(e);
      @(negedge clk);
    end
    stepEn = 1'b0;
    if (nBits == nCur) modelAdvance(rc);
  endtask

  // Monitor: compares each stepping cycle against the queue
  always @(negedge clk) begin
    #3;
    if (rstN && stepEn && !loadEn && !finished) begin
      if (q.size() == 0) begin
        check(1'b0, "R2", "scoreboard empty", 0, 1);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(keyBit === e.b, e.req, "keyBit", keyBit, e.b);
        check(lastBit === e.last, "R9", "lastBit (width R7)", lastBit, e.last);
      end
    end
  end

  task automatic finishRun();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    nRun++;
    nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  task automatic runConfig(input logic [2:0] sel, input logic [1:0] mcode,
                           input longint unsigned seed);
    loadKey(sel, mcode, seed, seed * 64'd3 + 64'h1357, ~seed, seed ^ 64'h0F0F_33CC_5A5A_9669, 1'b0);
    for (int r = 0; r < mCur + 3; r++) stepRound(nCur, (r == 1) ? 5 : -1);
  endtask

  initial begin
    rstN = 1'b0;
    wordSel = 3'd0; modeSel = 2'd0;
    loadEn = 1'b0; loadBit = 1'b0; stepEn = 1'b0; rcBit = 1'b0;
    tagOverride = "";
    mCur = 2; nCur = 16; roundCnt = 0;
    repeat (3) @(negedge clk);
    #3;
    check(keyBit === 1'b0, "R1", "keyBit in reset", keyBit, 0);
    check(lastBit === 1'b0, "R1", "lastBit in reset", lastBit, 0);
    rstN = 1'b1;
    @(negedge clk);
    #3;
    check(keyBit === 1'b0, "R1", "keyBit after reset", keyBit, 0);
    @(negedge clk);

    // Widths and word counts across R3, R4, R5 and R7
    runConfig(3'd0, 2'd0, 64'h1918_1110_0908_0100);
    runConfig(3'd1, 2'd1, 64'hA5C3_0F1E_2D3C_4B5A);
    runConfig(3'd2, 2'd2, 64'h0123_4567_89AB_CDEF);
    runConfig(3'd0, 2'd3, 64'hFEDC_BA98_7654_3210);
    runConfig(3'd3, 2'd0, 64'h7777_1111_EEEE_2222);
    runConfig(3'd4, 2'd1, 64'hDEAD_BEEF_CAFE_F00D);
    runConfig(3'd7, 2'd2, 64'h8000_0000_0000_0001);

    // R6: all-zero key exposes the constant word on the first new word
    tagOverride = "R6";
    loadKey(3'd0, 2'd0, 0, 0, 0, 0, 1'b0);
    for (int r = 0; r < 4; r++) stepRound(nCur, -1);
    tagOverride = "";

    // R10: load during a partial round, with stepEn also high
    loadKey(3'd2, 2'd1, 64'h1111_2222, 64'h3333_4444, 64'h5555_6666, 0, 1'b0);
    stepRound(7, -1);
    tagOverride = "R10";
    loadKey(3'd1, 2'd2, 64'hABCDEF, 64'h123456, 64'h0F0F0F, 64'hC3C3C3, 1'b1);
    stepRound(nCur, -1);
    tagOverride = "";
    for (int r = 0; r < 5; r++) stepRound(nCur, -1);

    repeat (2) @(negedge clk);
    check(q.size() == 0, "R2", "scoreboard drained", q.size(), 0);
    finishRun();
  end

endmodule